// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the sync and blanking waveforms for a raster display. Software supplies a horizontal timing word, a vertical timing word and a length word, and these set the timing. A horizontal sequencer runs on every pixel clock. A vertical sequencer, built from the same logic, moves forward one step at the end of each line. Each axis passes through four phases in a fixed order: sync pulse, delay before the visible gate, the visible gate itself, and a tail that runs up to the programmed total.

The block drives horizontal sync, vertical sync, composite sync and blank. Each of these four outputs has its own polarity bit. While a pixel is visible, the block also gives its column and row inside the visible window. A one-clock start-of-frame strobe lets a downstream pixel fetcher line up with the raster. When the enable input is low, both counters are held at zero and every output stays at its inactive level.

Top module: `raster_timing_gen`

## Requirements
- R1: Each timing word (`htim_i`, `vtim_i`) carries the gate length in bits 15:0, the delay length in bits 23:16 and the sync length in bits 31:24.
- R2: `hvlen_i` carries the vertical total in bits 15:0 and the horizontal total in bits 31:16.
- R3: Within a line, the sync, delay and gate phases follow in that order. Each phase lasts its field value plus one clocks, so a field of zero still gives one clock. Internal horizontal sync is active during the sync phase.
- R4: A line lasts horizontal total plus one clocks. A frame lasts vertical total plus one lines. The vertical position changes only on the last clock of a line, and the frame wraps only at the last clock of a line.
- R5: Internal blank is active except when both axes are in their gate phase. This gives gate plus one visible pixels per line and gate plus one visible lines per frame.
- R6: While a pixel is visible, `pix_x_o` and `pix_y_o` give its column and row counted from 0 at the first visible pixel. Both are 0 while blanked.
- R7: Internal composite sync is the OR of internal horizontal sync and internal vertical sync.
- R8: Each output is the internal active-high signal XOR its polarity bit: `pol_hsync_i`, `pol_vsync_i`, `pol_csync_i` and `pol_blank_i` act independently.
- R9: While `en_i` is low, every output equals its polarity bit, the coordinates and `sof_o` are 0, and both counters are forced to 0. Raising `en_i` restarts at the first clock of a frame.
- R10: `sof_o` is high for exactly the first clock of each frame (column count 0, line count 0) while enabled.
- R11: A line of total 345 with gate 340 and a frame of total 245 with gate 240 (sync and delay 0) runs correctly.
- R12: After reset the counters are at zero, so the first enabled clock is a start-of-frame clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| htim_i | input | 32 | Horizontal sync, delay and gate lengths |
| vtim_i | input | 32 | Vertical sync, delay and gate lengths |
| hvlen_i | input | 32 | Horizontal and vertical totals |
| pol_hsync_i | input | 1 | Invert horizontal sync |
| pol_vsync_i | input | 1 | Invert vertical sync |
| pol_csync_i | input | 1 | Invert composite sync |
| pol_blank_i | input | 1 | Invert blank |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blank |
| pix_x_o | output | 16 | Visible column |
| pix_y_o | output | 16 | Visible row |
| sof_o | output | 1 | Start-of-frame strobe |

## Verification
Two events fall on the same clock: the horizontal line wrap and the vertical advance, which may be a vertical phase change or the frame wrap. Every configuration is run across at least one full frame boundary, and tiny totals make these coincidences occur often. The bench compares every output on every clock against a position model that counts columns and lines from the programmed fields. It judges the coincidence by whether vertical sync and the start-of-frame strobe appear on exactly the expected clocks. A separate test drops the enable in the middle of the visible window, which collides an in-progress gate with the forced idle state.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    parameter int SYNC_W = 8;
    parameter int DLY_W  = 8;
    parameter int GATE_W = 16;
    parameter int TOT_W  = 16;

    localparam int TIM_W    = SYNC_W + DLY_W + GATE_W;
    localparam int LEN_W    = 2 * TOT_W;
    localparam int GATE_LSB = 0;
    localparam int DLY_LSB  = GATE_LSB + GATE_W;
    localparam int SYNC_LSB = DLY_LSB + DLY_W;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_DELAY = 2'd1,
        PH_GATE  = 2'd2,
        PH_TAIL  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SYNC_W-1:0] sync_len;
        logic [DLY_W-1:0]  dly_len;
        logic [GATE_W-1:0] gate_len;
        logic [TOT_W-1:0]  total;
    } axis_cfg_t;

    typedef struct packed {
        phase_e           phase;
        logic [TOT_W-1:0] pcnt;
        logic [TOT_W-1:0] tcnt;
    } axis_st_t;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic csync;
        logic blank;
    } sync_set_t;

    function automatic axis_cfg_t unpack_cfg(input logic [TIM_W-1:0] word,
                                             input logic [TOT_W-1:0] tot);
        axis_cfg_t c;
        c.sync_len = word[SYNC_LSB +: SYNC_W];
        c.dly_len  = word[DLY_LSB +: DLY_W];
        c.gate_len = word[GATE_LSB +: GATE_W];
        c.total    = tot;
        return c;
    endfunction

endpackage

// File: rtl/rtg_axis_seq.sv
module rtg_axis_seq
    import rtg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             step_i,
    input  axis_cfg_t        cfg_i,
    output logic             in_sync_o,
    output logic             in_gate_o,
    output logic [TOT_W-1:0] pos_o,
    output logic [TOT_W-1:0] tcnt_o,
    output logic             wrap_o
);

    axis_st_t st_d, st_q;
    logic     at_total;

    // next-state process
    always_comb begin
        st_d     = st_q;
        at_total = (st_q.tcnt == cfg_i.total);
        if (!en_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (at_total) begin
                st_d = '0;
            end else begin
                st_d.tcnt = st_q.tcnt + TOT_W'(1);
                st_d.pcnt = st_q.pcnt + TOT_W'(1);
                unique case (st_q.phase)
                    PH_SYNC: begin
                        if (st_q.pcnt == TOT_W'(cfg_i.sync_len)) begin
                            st_d.phase = PH_DELAY;
                            st_d.pcnt  = '0;
                        end
                    end
                    PH_DELAY: begin
                        if (st_q.pcnt == TOT_W'(cfg_i.dly_len)) begin
                            st_d.phase = PH_GATE;
                            st_d.pcnt  = '0;
                        end
                    end
                    PH_GATE: begin
                        if (st_q.pcnt == TOT_W'(cfg_i.gate_len)) begin
                            st_d.phase = PH_TAIL;
                            st_d.pcnt  = '0;
                        end
                    end
                    default: begin
                        st_d.pcnt = st_q.pcnt;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_sync_o = (st_q.phase == PH_SYNC);
    assign in_gate_o = (st_q.phase == PH_GATE);
    assign pos_o     = st_q.pcnt;
    assign tcnt_o    = st_q.tcnt;
    assign wrap_o    = en_i && step_i && at_total;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && step_i && st_q.tcnt == cfg_i.total) |=> (st_q.tcnt == '0 && st_q.phase == PH_SYNC)); // R4

    AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !step_i) |=> $stable(st_q)); // R4

    AST_GATE_NOT_BACK_TO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && step_i && st_q.phase == PH_GATE && st_q.tcnt != cfg_i.total)
            |=> (st_q.phase == PH_GATE || st_q.phase == PH_TAIL)); // R3

endmodule

// File: rtl/rtg_out_stage.sv
module rtg_out_stage
    import rtg_pkg::*;
(
    input  logic             en_i,
    input  logic             h_sync_i,
    input  logic             v_sync_i,
    input  logic             h_gate_i,
    input  logic             v_gate_i,
    input  logic [TOT_W-1:0] h_pos_i,
    input  logic [TOT_W-1:0] v_pos_i,
    input  logic             h_first_i,
    input  logic             v_first_i,
    input  sync_set_t        pol_i,
    output sync_set_t        sync_o,
    output logic [TOT_W-1:0] pix_x_o,
    output logic [TOT_W-1:0] pix_y_o,
    output logic             sof_o
);

    sync_set_t act_d;
    logic      vis_d;

    always_comb begin
        vis_d       = en_i && h_gate_i && v_gate_i;
        act_d.hsync = en_i && h_sync_i;
        act_d.vsync = en_i && v_sync_i;
        act_d.csync = act_d.hsync || act_d.vsync;
        act_d.blank = en_i && !vis_d;
        sync_o      = act_d ^ pol_i;
        pix_x_o     = vis_d ? h_pos_i : '0;
        pix_y_o     = vis_d ? v_pos_i : '0;
        sof_o       = en_i && h_first_i && v_first_i;
    end

    always_comb begin
        AST_CSYNC_WHEN_EITHER: assert (!(en_i && (h_sync_i || v_sync_i)) || act_d.csync); // R7
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [TIM_W-1:0] htim_i,
    input  logic [TIM_W-1:0] vtim_i,
    input  logic [LEN_W-1:0] hvlen_i,
    input  logic             pol_hsync_i,
    input  logic             pol_vsync_i,
    input  logic             pol_csync_i,
    input  logic             pol_blank_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             csync_o,
    output logic             blank_o,
    output logic [TOT_W-1:0] pix_x_o,
    output logic [TOT_W-1:0] pix_y_o,
    output logic             sof_o
);

    axis_cfg_t        h_cfg, v_cfg;
    logic             h_sync, v_sync, h_gate, v_gate, h_wrap, v_wrap;
    logic [TOT_W-1:0] h_pos, v_pos, h_tcnt, v_tcnt;
    sync_set_t        pol, sync_out;

    assign h_cfg = unpack_cfg(htim_i, hvlen_i[TOT_W +: TOT_W]);
    assign v_cfg = unpack_cfg(vtim_i, hvlen_i[0 +: TOT_W]);
    assign pol   = '{hsync: pol_hsync_i, vsync: pol_vsync_i,
                     csync: pol_csync_i, blank: pol_blank_i};

    rtg_axis_seq u_hseq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .step_i    (1'b1),
        .cfg_i     (h_cfg),
        .in_sync_o (h_sync),
        .in_gate_o (h_gate),
        .pos_o     (h_pos),
        .tcnt_o    (h_tcnt),
        .wrap_o    (h_wrap)
    );

    rtg_axis_seq u_vseq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .step_i    (h_wrap),
        .cfg_i     (v_cfg),
        .in_sync_o (v_sync),
        .in_gate_o (v_gate),
        .pos_o     (v_pos),
        .tcnt_o    (v_tcnt),
        .wrap_o    (v_wrap)
    );

    rtg_out_stage u_out (
        .en_i      (en_i),
        .h_sync_i  (h_sync),
        .v_sync_i  (v_sync),
        .h_gate_i  (h_gate),
        .v_gate_i  (v_gate),
        .h_pos_i   (h_pos),
        .v_pos_i   (v_pos),
        .h_first_i (h_tcnt == '0),
        .v_first_i (v_tcnt == '0),
        .pol_i     (pol),
        .sync_o    (sync_out),
        .pix_x_o   (pix_x_o),
        .pix_y_o   (pix_y_o),
        .sof_o     (sof_o)
    );

    assign hsync_o = sync_out.hsync;
    assign vsync_o = sync_out.vsync;
    assign csync_o = sync_out.csync;
    assign blank_o = sync_out.blank;

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (h_tcnt == '0 && v_tcnt == '0)); // R9

    AST_FRAME_WRAP_AT_EOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_wrap |-> h_wrap); // R4

    AST_SOF_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sof_o |-> (blank_o != pol_blank_i)); // R10

    AST_COORD_IN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && blank_o == pol_blank_i) |-> (pix_x_o <= h_cfg.gate_len && pix_y_o <= v_cfg.gate_len)); // R6

endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;

    localparam int PERIOD = 20;
    localparam int WD_CYC = 150000;

    typedef struct packed {
        logic [31:0] ht;
        logic [31:0] vt;
        logic [31:0] len;
        logic [3:0]  pol;     // {hsync, vsync, csync, blank}
        logic [7:0]  frames;
        logic [31:0] vis;     // expected visible pixels per frame
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h0102_0005, 32'h0001_0002, 32'h000E_0007, 4'b0000, 8'd2, 32'd18},
        '{32'h0000_0003, 32'h0100_0001, 32'h0006_0005, 4'b1111, 8'd2, 32'd8},
        '{32'h0301_0007, 32'h0200_0003, 32'h000F_0009, 4'b0101, 8'd2, 32'd32},
        '{32'h0002_0000, 32'h0000_0000, 32'h0005_0003, 4'b1010, 8'd3, 32'd1},
        '{32'h0000_0154, 32'h0000_00F0, 32'h0159_00F5, 4'b0000, 8'd1, 32'd82181}
    };

    logic        clk = 0;
    logic        rst_n, en;
    logic [31:0] htim, vtim, hvlen;
    logic [3:0]  pol;
    logic        hsync, vsync, csync, blank, sof;
    logic [15:0] pix_x, pix_y;

    int checks = 0, errors = 0;
    int hc = 0, vc = 0;
    int mism, vis_cnt, sof_cnt;
    logic [36:0] first_act, first_exp;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    raster_timing_gen dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en),
        .htim_i(htim), .vtim_i(vtim), .hvlen_i(hvlen),
        .pol_hsync_i(pol[3]), .pol_vsync_i(pol[2]),
        .pol_csync_i(pol[1]), .pol_blank_i(pol[0]),
        .hsync_o(hsync), .vsync_o(vsync), .csync_o(csync), .blank_o(blank),
        .pix_x_o(pix_x), .pix_y_o(pix_y), .sof_o(sof)
    );

    function automatic logic [36:0] model(input int h, input int v, input logic e);
        int hs, hst, hg, vs, vst, vg;
        logic hsi, vsi, hgi, vgi, bi;
        logic [15:0] x, y;
        hs  = int'(htim[31:24]);
        hst = hs + int'(htim[23:16]) + 2;
        hg  = int'(htim[15:0]);
        vs  = int'(vtim[31:24]);
        vst = vs + int'(vtim[23:16]) + 2;
        vg  = int'(vtim[15:0]);
        hsi = e && (h <= hs);
        vsi = e && (v <= vs);
        hgi = (h >= hst) && (h <= hst + hg);
        vgi = (v >= vst) && (v <= vst + vg);
        bi  = e && !(hgi && vgi);
        x   = (e && !bi) ? 16'(h - hst) : 16'h0;
        y   = (e && !bi) ? 16'(v - vst) : 16'h0;
        return {hsi ^ pol[3], vsi ^ pol[2], (hsi | vsi) ^ pol[1], bi ^ pol[0],
                x, y, e && h == 0 && v == 0};
    endfunction

    function automatic logic [36:0] actual();
        return {hsync, vsync, csync, blank, pix_x, pix_y, sof};
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare every clock against the position model, then advance it
    task automatic run_clks(input int n);
        for (int i = 0; i < n; i++) begin
            logic [36:0] e, a;
            #1;
            e = model(hc, vc, en);
            a = actual();
            if (e !== a) begin
                if (mism == 0) begin first_act = a; first_exp = e; end
                mism++;
            end
            if (en && e[33] == pol[0]) vis_cnt++;
            if (sof) sof_cnt++;
            @(negedge clk);
            if (!en) begin
                hc = 0; vc = 0;
            end else if (hc == int'(hvlen[31:16])) begin
                hc = 0;
                vc = (vc == int'(hvlen[15:0])) ? 0 : vc + 1;
            end else begin
                hc++;
            end
        end
    endtask

    task automatic clear_stats();
        mism = 0; vis_cnt = 0; sof_cnt = 0;
        first_act = '0; first_exp = '0;
    endtask

    initial begin
        #(WD_CYC * PERIOD);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; en = 0;
        htim = VECS[0].ht; vtim = VECS[0].vt; hvlen = VECS[0].len;
        pol = 4'b0101;
        clear_stats();
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state with enable low: outputs equal polarity bits
        chk(actual() == {4'b0101, 16'h0, 16'h0, 1'b0}, "R12 reset idle outputs",
            64'(actual()), 64'({4'b0101, 33'h0}));
        @(negedge clk);
        rst_n = 1; en = 1;
        #1;
        // R12 first enabled clock is a frame start: sof high, hsync active (pol 0), vsync active (pol 1 -> low)
        chk(sof === 1'b1 && hsync === 1'b1 && vsync === 1'b0, "R12 first clock after reset",
            64'({sof, hsync, vsync}), 64'(3'b110));
        @(negedge clk);
        hc = 1; vc = 0;

        // table of configurations, each run over whole frames
        foreach (VECS[k]) begin
            int flen;
            en = 0;
            clear_stats();
            run_clks(2);
            // R9 counters cleared and outputs idle while disabled
            chk(mism == 0, "R9 idle between configurations", 64'(first_act), 64'(first_exp));
            htim = VECS[k].ht; vtim = VECS[k].vt; hvlen = VECS[k].len; pol = VECS[k].pol;
            en = 1;
            clear_stats();
            flen = (int'(hvlen[31:16]) + 1) * (int'(hvlen[15:0]) + 1);
            run_clks(flen * int'(VECS[k].frames));
            chk(mism == 0, (k == 4) ? "R11 R1 R2 R3 R4 R6 R7 R8 cycle match"
                                    : "R1 R2 R3 R4 R6 R7 R8 cycle match",
                64'(first_act), 64'(first_exp));
            chk(vis_cnt == int'(VECS[k].vis) * int'(VECS[k].frames), "R5 visible pixel count",
                64'(vis_cnt), 64'(int'(VECS[k].vis) * int'(VECS[k].frames)));
            chk(sof_cnt == int'(VECS[k].frames), "R10 start-of-frame count",
                64'(sof_cnt), 64'(VECS[k].frames));
        end

        // R9 drop enable in the middle of the visible window
        en = 0;
        run_clks(1);
        htim = VECS[0].ht; vtim = VECS[0].vt; hvlen = VECS[0].len; pol = 4'b1100;
        en = 1;
        clear_stats();
        run_clks(52);
        #1;
        chk(pix_x == 16'd2 && pix_y == 16'd0 && blank == 1'b0, "R6 mid-window coordinates",
            64'({pix_x, pix_y, blank}), 64'({16'd2, 16'd0, 1'b0}));
        @(negedge clk);
        run_clks(0);
        en = 0;
        #1;
        chk(actual() == {4'b1100, 33'h0}, "R9 outputs idle right after enable drop",
            64'(actual()), 64'({4'b1100, 33'h0}));
        @(negedge clk);
        hc = 0; vc = 0;
        run_clks(4);
        en = 1;
        #1;
        chk(sof === 1'b1 && hsync === 1'b0, "R9 restart at frame start",
            64'({sof, hsync}), 64'(2'b10));
        @(negedge clk);
        hc = 1; vc = 0;
        run_clks(40);
        chk(mism == 0, "R9 R10 model match around disable", 64'(first_act), 64'(first_exp));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule